// File: doc/BRIEF.md
# Asynchronous Serial Frame Engine

This block is the line side of a programmed-I/O serial port. It turns bytes into asynchronous frames on a single transmit wire and recovers bytes from a single receive wire. A three-bit format code chooses the frame shape: seven or eight data bits, even, odd or no parity, and one or two stop bits. A two-bit divide code picks how many pulses of an upstream bit-clock enable make one bit time: 1, 16 or 64. The remaining divide code parks the engine in an idle state. That upstream enable comes from a baud generator outside this block. Typical line rates run from 110 to 9600 baud.

A byte to send is offered with a valid/ready handshake. A received byte comes back as a one-cycle strobe, with a framing-error flag and a parity-error flag. A break input forces the transmit line to the space level for as long as it is held.

Top module: `serframe_engine`

## Requirements
- R1: After synchronous reset (with a divide code other than 11 and break low), `txd` is high, `tx_ready` is high and no `rx_valid` strobe appears.
- R2: A frame is one low start bit, then the data bits least significant first, then the parity bit if the format has one, then the stop bits, which are high. Format codes: 000 = 7 data/even/2 stop, 001 = 7/odd/2, 010 = 7/even/1, 011 = 7/odd/1, 100 = 8/none/2, 101 = 8/none/1, 110 = 8/even/1, 111 = 8/odd/1. Even parity makes the count of ones over data and parity even.
- R3: Each transmitted bit lasts exactly N pulses of `bit_en` after the accepting clock edge. N is 1 for divide code 00, 16 for 01 and 64 for 10.
- R4: `tx_ready` is high only while no frame is in progress. A byte is taken on a clock edge with `tx_valid` and `tx_ready` both high, and `txd` goes low on that edge. `tx_valid` while `tx_ready` is low is ignored.
- R5: While `brk_en` is high (and the divide code is not 11), `txd` is held low and `tx_ready` is low. Releasing it returns the line high and ready.
- R6: Divide code 11 holds the engine idle: `txd` high, `tx_ready` low, and no reception even with `rxd` low.
- R7: The receiver delivers each byte with `rx_valid` on the clock after its last stop-bit sample. In seven-bit formats bit 7 of `rx_data` is 0.
- R8: A low level sampled where a stop bit is expected sets `rx_frame_err` with that byte.
- R9: A parity bit that does not match the format's parity sets `rx_par_err` with that byte.
- R10: In divide-by-16 and divide-by-64 modes, a start bit is confirmed at its middle. A low pulse shorter than half a bit starts no reception. Each later bit is sampled at its centre.
- R11: `rx_valid` is a single-cycle strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit-clock enable pulse from the upstream baud generator |
| div_sel | input | 2 | Divide code: 00 = 1, 01 = 16, 10 = 64, 11 = hold idle |
| fmt_sel | input | 3 | Frame format code (see R2) |
| brk_en | input | 1 | Force the transmit line to the space level |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmitter can take a byte |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line, idle high |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe: new byte in `rx_data` |
| rx_frame_err | output | 1 | Stop-bit error for the byte in `rx_data` |
| rx_par_err | output | 1 | Parity error for the byte in `rx_data` |

## Verification
A transmitter whose bit counter or shift register has gone wrong shows up on `txd` within one bit time: a bit comes out with the wrong value or lasts the wrong length. The bench checks every bit at both its first and its last enable pulse. A receiver in the wrong state shows up at the end of the frame, at the latest, as a missing, doubled or corrupted `rx_valid` byte, or as a wrong error flag. Looping `txd` back to `rxd` in every format and divide mode ties the two halves together. Directed drives of `rxd` cover bad stop bits, bad parity and short start glitches.

// File: rtl/serframe_pkg.sv
package serframe_pkg;
  localparam int DIV_MID = 16;
  localparam int DIV_MAX = 64;
  localparam int CNT_W   = $clog2(DIV_MAX);
  localparam int PAY_W   = 11;

  typedef struct packed {
    logic [3:0] dbits;
    logic       par_en;
    logic       par_odd;
    logic [1:0] stops;
  } fmt_t;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_t;

  function automatic fmt_t decode_fmt(input logic [2:0] code);
    fmt_t f;
    f.par_odd = code[0];
    if (!code[2]) begin
      f.dbits  = 4'd7;
      f.par_en = 1'b1;
      f.stops  = code[1] ? 2'd1 : 2'd2;
    end else begin
      f.dbits  = 4'd8;
      f.par_en = code[1];
      f.stops  = (code[1:0] == 2'b00) ? 2'd2 : 2'd1;
    end
    return f;
  endfunction

  // enable pulses per bit, minus one
  function automatic logic [CNT_W-1:0] div_last(input logic [1:0] sel);
    case (sel)
      2'b01:   return CNT_W'(DIV_MID - 1);
      2'b10:   return CNT_W'(DIV_MAX - 1);
      default: return '0;
    endcase
  endfunction

  // enable pulses from start detection to mid start bit, minus one
  function automatic logic [CNT_W-1:0] half_last(input logic [1:0] sel);
    case (sel)
      2'b01:   return CNT_W'(DIV_MID / 2 - 1);
      2'b10:   return CNT_W'(DIV_MAX / 2 - 1);
      default: return '0;
    endcase
  endfunction

  // bits after the start bit
  function automatic logic [3:0] payload_len(input fmt_t f);
    return f.dbits + {3'b000, f.par_en} + {2'b00, f.stops};
  endfunction

  function automatic logic [PAY_W-1:0] payload(input fmt_t f, input logic [7:0] d);
    logic [PAY_W-1:0] v;
    logic [7:0]       m;
    v = '1;
    m = (f.dbits == 4'd8) ? 8'hFF : 8'h7F;
    for (int i = 0; i < 8; i++)
      if (i < int'(f.dbits)) v[i] = d[i];
    if (f.par_en) v[f.dbits] = (^(d & m)) ^ f.par_odd;
    return v;
  endfunction
endpackage

// File: rtl/serframe_sync.sv
module serframe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/serframe_tx.sv
module serframe_tx
  import serframe_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       hold,
  input  logic       bit_en,
  input  logic       brk,
  input  logic [1:0] div_sel,
  input  logic [2:0] fmt_sel,
  input  logic [7:0] data,
  input  logic       valid,
  output logic       ready,
  output logic       txd
);
  logic             busy;
  logic             txd_q;
  logic [PAY_W-1:0] shreg;
  logic [3:0]       left;
  logic [CNT_W-1:0] cnt;
  fmt_t             fmt;
  logic [CNT_W-1:0] last;

  assign fmt   = decode_fmt(fmt_sel);
  assign last  = div_last(div_sel);
  assign ready = !busy && !brk && !hold && txd_q;
  assign txd   = txd_q;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      busy  <= 1'b0;
      txd_q <= 1'b1;
      shreg <= '1;
      left  <= '0;
      cnt   <= '0;
    end else if (brk) begin
      busy  <= 1'b0;
      txd_q <= 1'b0;
      cnt   <= '0;
    end else if (valid && ready) begin
      busy  <= 1'b1;
      txd_q <= 1'b0;
      shreg <= payload(fmt, data);
      left  <= payload_len(fmt);
      cnt   <= '0;
    end else if (!busy) begin
      txd_q <= 1'b1;
    end else if (bit_en) begin
      if (cnt == last) begin
        cnt <= '0;
        if (left == 4'd0) begin
          busy  <= 1'b0;
          txd_q <= 1'b1;
        end else begin
          txd_q <= shreg[0];
          shreg <= {1'b1, shreg[PAY_W-1:1]};
          left  <= left - 4'd1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/serframe_rx.sv
module serframe_rx
  import serframe_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       hold,
  input  logic       bit_en,
  input  logic       rxd,
  input  logic [1:0] div_sel,
  input  logic [2:0] fmt_sel,
  output logic [7:0] data,
  output logic       valid,
  output logic       ferr,
  output logic       perr
);
  rx_state_t        st;
  logic [CNT_W-1:0] cnt;
  logic [3:0]       k;
  fmt_t             fl;
  logic             acc;
  logic             perr_q;
  logic             ferr_q;
  logic [7:0]       dat;
  logic [CNT_W-1:0] last;
  logic [CNT_W-1:0] half;

  assign last = div_last(div_sel);
  assign half = half_last(div_sel);

  always_ff @(posedge clk) begin
    valid <= 1'b0;
    if (rst || hold) begin
      st     <= RX_IDLE;
      cnt    <= '0;
      k      <= '0;
      fl     <= '0;
      acc    <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
      dat    <= '0;
      if (rst) begin
        data <= '0;
        ferr <= 1'b0;
        perr <= 1'b0;
      end
    end else if (bit_en) begin
      case (st)
        RX_IDLE: begin
          if (!rxd) begin
            fl     <= decode_fmt(fmt_sel);
            cnt    <= '0;
            k      <= '0;
            acc    <= 1'b0;
            perr_q <= 1'b0;
            ferr_q <= 1'b0;
            dat    <= '0;
            st     <= (div_sel == 2'b00) ? RX_BITS : RX_START;
          end
        end
        RX_START: begin
          if (cnt == half) begin
            cnt <= '0;
            st  <= rxd ? RX_IDLE : RX_BITS;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_BITS: begin
          if (cnt == last) begin
            cnt <= '0;
            k   <= k + 4'd1;
            if (k < fl.dbits) begin
              dat[k[2:0]] <= rxd;
              acc         <= acc ^ rxd;
            end else if (fl.par_en && (k == fl.dbits)) begin
              perr_q <= acc ^ rxd ^ fl.par_odd;
            end else if (!rxd) begin
              ferr_q <= 1'b1;
            end
            if (k == payload_len(fl) - 4'd1) begin
              st    <= RX_IDLE;
              valid <= 1'b1;
              data  <= dat;
              ferr  <= ferr_q | !rxd;
              perr  <= perr_q;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serframe_engine.sv
module serframe_engine
  import serframe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_en,
  input  logic [1:0] div_sel,
  input  logic [2:0] fmt_sel,
  input  logic       brk_en,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic       txd,
  input  logic       rxd,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rx_frame_err,
  output logic       rx_par_err
);
  logic hold;
  logic rxd_s;

  assign hold = (div_sel == 2'b11);

  serframe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(rxd), .dout(rxd_s)
  );

  serframe_tx u_tx (
    .clk(clk), .rst(rst), .hold(hold), .bit_en(bit_en), .brk(brk_en),
    .div_sel(div_sel), .fmt_sel(fmt_sel), .data(tx_data), .valid(tx_valid),
    .ready(tx_ready), .txd(txd)
  );

  serframe_rx u_rx (
    .clk(clk), .rst(rst), .hold(hold), .bit_en(bit_en), .rxd(rxd_s),
    .div_sel(div_sel), .fmt_sel(fmt_sel), .data(rx_data), .valid(rx_valid),
    .ferr(rx_frame_err), .perr(rx_par_err)
  );
endmodule

// File: rtl/serframe_chk.sv
module serframe_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] div_sel,
  input logic       brk_en,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       txd,
  input logic       rx_valid
);
  a_r4_start_on_accept: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> !txd);

  a_r4_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> !tx_ready);

  a_r5_break_space: assert property (@(posedge clk) disable iff (rst)
    (brk_en && div_sel != 2'b11) |=> !txd);

  a_r6_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (div_sel == 2'b11) |=> (txd && !rx_valid));

  a_r11_single_strobe: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
endmodule

bind serframe_engine serframe_chk u_chk (
  .clk(clk), .rst(rst), .div_sel(div_sel), .brk_en(brk_en),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd), .rx_valid(rx_valid)
);

// File: tb/sim_serframe_engine.sv
module sim_serframe_engine;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ce = 1'b0;
  logic       ce_seen = 1'b0;
  int         cediv = 0;
  logic [1:0] div_sel = 2'b01;
  logic [2:0] fmt_sel = 3'b101;
  logic       brk_en = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       loop = 1'b1;
  logic       rxd_drv = 1'b1;
  logic       tx_ready, txd, rxd, rx_valid, rx_frame_err, rx_par_err;
  logic [7:0] rx_data;

  int n_chk = 0, n_bad = 0, rx_cnt = 0, pulse_bad = 0;
  logic [7:0] rx_last = 8'h00;
  logic rx_fe = 1'b0, rx_pe = 1'b0, prev_v = 1'b0;
  bit done = 0;

  always #5 clk = ~clk;

  assign rxd = loop ? txd : rxd_drv;

  serframe_engine u0 (
    .clk(clk), .rst(rst), .bit_en(ce), .div_sel(div_sel), .fmt_sel(fmt_sel),
    .brk_en(brk_en), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .txd(txd), .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_frame_err(rx_frame_err), .rx_par_err(rx_par_err)
  );

  // bit-clock enable: one pulse every four clocks
  always @(negedge clk) begin
    ce    <= (cediv == 3);
    cediv <= (cediv == 3) ? 0 : cediv + 1;
  end
  always @(posedge clk) ce_seen <= ce;

  // receive monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin
        rx_cnt++;
        rx_last = rx_data;
        rx_fe   = rx_frame_err;
        rx_pe   = rx_par_err;
        if (prev_v) pulse_bad++;
      end
      prev_v = rx_valid;
    end
  end

  // stimulus table: {format, divide, byte}
  localparam logic [12:0] VEC [8] = '{
    {3'b000, 2'b00, 8'hA5},
    {3'b001, 2'b01, 8'h3C},
    {3'b010, 2'b00, 8'hFF},
    {3'b011, 2'b01, 8'h01},
    {3'b100, 2'b00, 8'h80},
    {3'b101, 2'b10, 8'h5A},
    {3'b110, 2'b01, 8'hC3},
    {3'b111, 2'b00, 8'h7E}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic wait_ce(input int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!ce_seen);
    end
  endtask

  function automatic int ratio(input logic [1:0] d);
    return (d == 2'b00) ? 1 : (d == 2'b01) ? 16 : 64;
  endfunction

  function automatic int nd(input logic [2:0] f);
    return f[2] ? 8 : 7;
  endfunction

  function automatic int np(input logic [2:0] f);
    return f[2] ? int'(f[1]) : 1;
  endfunction

  function automatic int blen(input logic [2:0] f);
    int stops;
    stops = f[2] ? ((f[1:0] == 2'b00) ? 2 : 1) : (f[1] ? 1 : 2);
    return 1 + nd(f) + np(f) + stops;
  endfunction

  // expected line levels, bit 0 = start bit
  function automatic logic [11:0] bframe(input logic [2:0] f, input logic [7:0] d);
    logic [11:0] v;
    logic p;
    v = '1;
    v[0] = 1'b0;
    p = f[0];
    for (int i = 0; i < nd(f); i++) begin
      v[1+i] = d[i];
      p = p ^ d[i];
    end
    if (np(f) == 1) v[1+nd(f)] = p;
    return v;
  endfunction

  task automatic send_frame(input logic [2:0] f, input logic [1:0] d, input logic [7:0] data);
    int n, L, rx0;
    logic [11:0] fr;
    logic [7:0] exp;
    bit shape_ok, time_ok;
    n   = ratio(d);
    L   = blen(f);
    fr  = bframe(f, data);
    exp = f[2] ? data : {1'b0, data[6:0]};
    @(negedge clk);
    fmt_sel = f; div_sel = d; loop = 1'b1;
    wait_ce(2);
    for (int i = 0; i < 1000 && !tx_ready; i++) @(negedge clk);
    rx0 = rx_cnt;
    tx_data = data; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    shape_ok = 1; time_ok = 1;
    for (int m = 0; m < L * n; m++) begin
      if (m > 0) wait_ce(1);
      if ((m % n == 0) && txd !== fr[m/n]) shape_ok = 0;
      if ((m % n == n - 1) && txd !== fr[m/n]) time_ok = 0;
    end
    wait_ce(1);
    chk(shape_ok, "R2 frame bits", {19'd0, f, data}, {20'd0, fr});
    chk(time_ok, "R3 bit duration", {30'd0, d}, n);
    chk(txd === 1'b1 && tx_ready === 1'b1, "R4 ready between frames", {txd, tx_ready}, 2'b11);
    wait_ce(2 * n);
    chk(rx_cnt == rx0 + 1 && rx_last == exp && !rx_fe && !rx_pe, "R7 loopback byte",
        {rx_cnt - rx0, rx_fe, rx_pe, rx_last}, {8'd1, 2'b00, exp});
  endtask

  task automatic drive_rx(input logic [11:0] fr, input int L, input int n);
    loop = 1'b0;
    wait_ce(1);
    for (int j = 0; j < L; j++) begin
      rxd_drv = fr[j];
      wait_ce(n);
    end
    rxd_drv = 1'b1;
    wait_ce(2 * n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      report();
      $finish;
    end
  end

  initial begin
    logic [11:0] fr;
    int rx0;
    repeat (6) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(txd === 1'b1 && tx_ready === 1'b1 && rx_cnt == 0, "R1 reset state",
        {txd, tx_ready, rx_cnt[7:0]}, {2'b11, 8'd0});

    // table walk: every format, all three divide modes (R2 R3 R4 R7)
    for (int i = 0; i < 8; i++)
      send_frame(VEC[i][12:10], VEC[i][9:8], VEC[i][7:0]);

    // R4: offer while busy is ignored
    @(negedge clk);
    fmt_sel = 3'b101; div_sel = 2'b01; loop = 1'b1;
    rx0 = rx_cnt;
    tx_data = 8'hA1; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    wait_ce(3);
    chk(tx_ready === 1'b0, "R4 busy not ready", tx_ready, 0);
    tx_data = 8'h5E; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    for (int i = 0; i < 2000 && !tx_ready; i++) @(negedge clk);
    wait_ce(40);
    chk(rx_cnt == rx0 + 1 && rx_last == 8'hA1, "R4 offer while busy ignored",
        {rx_cnt - rx0, rx_last}, {8'd1, 8'hA1});

    // R5 break
    @(negedge clk);
    brk_en = 1'b1;
    repeat (5) @(negedge clk);
    chk(txd === 1'b0 && tx_ready === 1'b0, "R5 break drives space", {txd, tx_ready}, 2'b00);
    repeat (40) @(negedge clk);
    chk(txd === 1'b0, "R5 break held", txd, 0);
    brk_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(txd === 1'b1 && tx_ready === 1'b1, "R5 break released", {txd, tx_ready}, 2'b11);
    wait_ce(40);

    // R6 hold idle
    rx0 = rx_cnt;
    @(negedge clk);
    div_sel = 2'b11; loop = 1'b0; rxd_drv = 1'b0;
    repeat (300) @(negedge clk);
    chk(txd === 1'b1 && tx_ready === 1'b0 && rx_cnt == rx0, "R6 hold idle",
        {txd, tx_ready, rx_cnt - rx0}, {2'b10, 8'd0});
    rxd_drv = 1'b1;
    repeat (10) @(negedge clk);
    div_sel = 2'b01;
    wait_ce(20);

    // R8 stop bit low
    rx0 = rx_cnt;
    fmt_sel = 3'b101;
    fr = bframe(3'b101, 8'h96);
    fr[9] = 1'b0;
    drive_rx(fr, 10, 16);
    chk(rx_cnt == rx0 + 1 && rx_last == 8'h96 && rx_fe && !rx_pe, "R8 framing error",
        {rx_cnt - rx0, rx_fe, rx_pe, rx_last}, {8'd1, 2'b10, 8'h96});
    wait_ce(20);

    // R9 parity mismatch
    rx0 = rx_cnt;
    fmt_sel = 3'b110;
    fr = bframe(3'b110, 8'h4D);
    fr[9] = ~fr[9];
    drive_rx(fr, 11, 16);
    chk(rx_cnt == rx0 + 1 && rx_last == 8'h4D && !rx_fe && rx_pe, "R9 parity error",
        {rx_cnt - rx0, rx_fe, rx_pe, rx_last}, {8'd1, 2'b01, 8'h4D});
    wait_ce(20);

    // R10 short start glitch, then a good frame
    rx0 = rx_cnt;
    fmt_sel = 3'b101;
    wait_ce(1);
    rxd_drv = 1'b0;
    wait_ce(4);
    rxd_drv = 1'b1;
    wait_ce(60);
    chk(rx_cnt == rx0, "R10 glitch rejected", rx_cnt - rx0, 0);
    drive_rx(bframe(3'b101, 8'h33), 10, 16);
    chk(rx_cnt == rx0 + 1 && rx_last == 8'h33 && !rx_fe && !rx_pe, "R10 centre sampling",
        {rx_cnt - rx0, rx_fe, rx_pe, rx_last}, {8'd1, 2'b00, 8'h33});

    // R11 strobe width over the whole run
    chk(pulse_bad == 0, "R11 single-cycle strobe", pulse_bad, 0);

    done = 1;
    report();
    $finish;
  end
endmodule